// File: doc/BRIEF.md
# Split-Transaction Ordering Queue

This block is the slave-side controller of a bus bridge that completes reads and writes through split transactions. Accesses from up to `NUM_MST` masters are served one at a time, in the order they arrived. Only the master being served has its access forwarded to the downstream port. Every other master gets a two-cycle SPLIT response, and its identifier is placed in an ordered waiting queue.

When the downstream side finishes, the controller raises that master's bit in the split-release vector for one cycle. It then waits for the master to retry, and answers the retry with OKAY and the fetched data. After that it releases the oldest waiting master. That master's retry is forwarded downstream in the same way.

A locked access that arrives while masters are waiting is placed ahead of all of them. The arbiter and the downstream bus master are outside this block. The bridge connects to them only through the release vector and a request/done handshake.

Top module: `split_order_bridge`

## Requirements
- R1: After reset, `s_ready` is 1, `s_resp` is OKAY (2'b00), `s_split_rel` is all zero and `d_req` is 0.
- R2: An access accepted (`s_sel` high while `s_ready` is high) with no access in service and no master waiting is forwarded. From the next cycle `d_req` is high, and `d_addr`, `d_write` and `d_wdata` carry the captured values. The master gets SPLIT (2'b11) for two cycles: `s_ready` is 0 in the first cycle and 1 in the second.
- R3: A master that accesses while another access is in service gets the same two-cycle SPLIT. It is appended to the waiting queue, which holds at most `NUM_MST` entries and is never pushed while full.
- R4: If `d_done` is sampled high at clock edge k, `d_req` is low after edge k. The served master's bit of `s_split_rel` is the only bit high, for exactly the one cycle after edge k+1.
- R5: When the released master retries, it gets OKAY with `s_ready` high in the next cycle, and `s_rdata` equals the `d_rdata` captured with `d_done`.
- R6: If masters are waiting when an access completes, the oldest one gets a one-cycle `s_split_rel` pulse in the cycle after the clock edge that follows the OKAY data phase.
- R7: The retry of a master released from the queue is forwarded downstream as in R2, and its rdata returns as in R4 and R5.
- R8: A locked access (`s_lock` high) that arrives while an access is in service gets SPLIT and is placed ahead of every master already waiting.
- R9: A waiting master that retries before it is released gets SPLIT again and is not queued a second time. It is released exactly once for its turn.
- R10: `d_req` stays high from forwarding until `d_done` is sampled, and only one downstream access is outstanding at any time.
- R11: The master in service that retries before its release gets SPLIT. It is not placed in the waiting queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_sel | input | 1 | Address phase valid for this slave |
| s_mst | input | MST_W | Identifier of the master driving the address phase |
| s_write | input | 1 | 1 for write, 0 for read |
| s_lock | input | 1 | Locked access |
| s_addr | input | ADDR_W | Access address |
| s_wdata | input | DATA_W | Write data (presented with the address in this simplified interface) |
| s_ready | output | 1 | Transfer ready |
| s_resp | output | 2 | Response: 2'b00 OKAY, 2'b11 SPLIT |
| s_rdata | output | DATA_W | Read data, valid in an OKAY data phase |
| s_split_rel | output | NUM_MST | One-hot split-release pulse, one bit per master |
| d_req | output | 1 | Downstream access request |
| d_write | output | 1 | Downstream access direction |
| d_addr | output | ADDR_W | Downstream address |
| d_wdata | output | DATA_W | Downstream write data |
| d_done | input | 1 | Downstream access finished |
| d_rdata | input | DATA_W | Downstream read data, valid with d_done |

## Verification
Two functions can fall in the same cycle: popping the oldest waiting master after a completion, and accepting a new SPLIT access from another master. The bench provokes this by driving a fresh master's address phase in the OKAY data phase of the returning master. The controller is then idle with a non-empty queue, so the pop and the push are sampled on the same clock edge. The check expects the new master to get SPLIT while the release pulse goes to the older waiting master. The newcomer must then be released only after that master has been fully served.

// File: rtl/split_order_pkg.sv
// Package: shared encodings for the split ordering controller.
// Assumes a single slave port and one downstream access at a time.
package split_order_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } resp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HELD,
        ST_RETURN,
        ST_GRANT
    } ctl_state_e;

    typedef enum logic [1:0] {
        RP_NONE,
        RP_SPLIT_WAIT,
        RP_SPLIT_DONE,
        RP_OKAY
    } rphase_e;

endpackage

// File: rtl/split_order_fifo.sv
// Module: ordered waiting queue of master identifiers.
// Holds up to NUM_MST identifiers in arrival order. It supports push at the
// tail, push at the head (locked accesses) and pop of the head, all in the
// same cycle. A membership vector tells the controller which masters are
// already waiting. Assumes MST_W bits are enough to index NUM_MST masters.
module split_order_fifo #(
    parameter int NUM_MST = 16,
    parameter int MST_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               push_front,
    input  logic [MST_W-1:0]   push_id,
    input  logic               pop,
    output logic [MST_W-1:0]   head_id,
    output logic               empty,
    output logic               full,
    output logic [NUM_MST-1:0] member
);
    localparam int CNT_W = $clog2(NUM_MST + 1);

    logic [MST_W-1:0]   slot  [NUM_MST];
    logic [MST_W-1:0]   nslot [NUM_MST];
    logic [CNT_W-1:0]   cnt, ncnt;
    logic [NUM_MST-1:0] mem_q, nmem;

    // Next-state: pop first, then insert at the tail or the head.
    always_comb begin
        nslot = slot;
        ncnt  = cnt;
        nmem  = mem_q;
        if (pop && cnt != '0) begin
            nmem[slot[0]] = 1'b0;
            for (int i = 0; i < NUM_MST - 1; i++) begin
                nslot[i] = slot[i+1];
            end
            nslot[NUM_MST-1] = '0;
            ncnt = cnt - 1'b1;
        end
        if (push && ncnt != CNT_W'(NUM_MST)) begin
            if (push_front) begin
                for (int i = NUM_MST - 1; i > 0; i--) begin
                    nslot[i] = nslot[i-1];
                end
                nslot[0] = push_id;
            end else begin
                for (int i = 0; i < NUM_MST; i++) begin
                    if (CNT_W'(i) == ncnt) nslot[i] = push_id;
                end
            end
            ncnt = ncnt + 1'b1;
            nmem[push_id] = 1'b1;
        end
    end

    // Register the queue contents, fill count and membership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            mem_q <= '0;
            for (int i = 0; i < NUM_MST; i++) slot[i] <= '0;
        end else begin
            cnt   <= ncnt;
            mem_q <= nmem;
            slot  <= nslot;
        end
    end

    assign head_id = slot[0];
    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(NUM_MST));
    assign member  = mem_q;

endmodule

// File: rtl/split_release_pulse.sv
// Module: registered one-hot split-release vector.
// Each bit is high for one cycle after the controller fires a release
// for that master. Assumes fire is never high in two consecutive cycles.
module split_release_pulse #(
    parameter int NUM_MST = 16,
    parameter int MST_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [MST_W-1:0]   id,
    output logic [NUM_MST-1:0] rel
);
    for (genvar g = 0; g < NUM_MST; g++) begin : g_bit
        // One flop per master: raise the bit for a matching release.
        always_ff @(posedge clk) begin
            if (!rst_n) rel[g] <= 1'b0;
            else        rel[g] <= fire && (id == MST_W'(g));
        end
    end

endmodule

// File: rtl/split_order_ctl.sv
// Module: slave-side controller of the split bridge.
// Decides for every accepted address phase whether it is forwarded,
// answered with SPLIT (and queued) or completed with OKAY. It sequences the
// downstream handshake and the release of masters. Assumes at most one
// address phase per cycle and that released masters eventually retry.
module split_order_ctl
    import split_order_pkg::*;
#(
    parameter int NUM_MST = 16,
    parameter int MST_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_sel,
    input  logic [MST_W-1:0]   s_mst,
    input  logic               s_write,
    input  logic               s_lock,
    input  logic [ADDR_W-1:0]  s_addr,
    input  logic [DATA_W-1:0]  s_wdata,
    output logic               s_ready,
    output logic [1:0]         s_resp,
    output logic [DATA_W-1:0]  s_rdata,
    output logic               d_req,
    output logic               d_write,
    output logic [ADDR_W-1:0]  d_addr,
    output logic [DATA_W-1:0]  d_wdata,
    input  logic               d_done,
    input  logic [DATA_W-1:0]  d_rdata,
    output logic               q_push,
    output logic               q_front,
    output logic [MST_W-1:0]   q_id,
    output logic               q_pop,
    input  logic               q_empty,
    input  logic [MST_W-1:0]   q_head,
    input  logic [NUM_MST-1:0] q_member,
    output logic               rel_fire,
    output logic [MST_W-1:0]   rel_id
);
    ctl_state_e        state;
    rphase_e           rph;
    logic [MST_W-1:0]  cur_id;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_wr;
    logic [DATA_W-1:0] cap_wdata;
    logic [DATA_W-1:0] rbuf;
    logic [DATA_W-1:0] rdata_q;

    logic acc, is_cur, known;
    logic serve_new, complete, split_rsp, enq;

    assign s_ready = (rph != RP_SPLIT_WAIT);
    assign s_resp  = (rph == RP_SPLIT_WAIT || rph == RP_SPLIT_DONE) ? RESP_SPLIT : RESP_OKAY;
    assign s_rdata = rdata_q;
    assign acc     = s_sel && s_ready;
    assign is_cur  = (s_mst == cur_id);
    assign known   = q_member[s_mst];

    // Classify the current address phase and decide on queue pops.
    always_comb begin
        serve_new = 1'b0;
        complete  = 1'b0;
        split_rsp = 1'b0;
        enq       = 1'b0;
        q_pop     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (acc && (q_empty || s_lock)) begin
                    serve_new = 1'b1;
                end else begin
                    if (!q_empty) q_pop = 1'b1;
                    if (acc) begin
                        split_rsp = 1'b1;
                        enq       = !known;
                    end
                end
            end
            ST_GRANT: begin
                if (acc) begin
                    if (is_cur) serve_new = 1'b1;
                    else begin
                        split_rsp = 1'b1;
                        enq       = !known;
                    end
                end
            end
            ST_RETURN: begin
                if (acc) begin
                    if (is_cur) complete = 1'b1;
                    else begin
                        split_rsp = 1'b1;
                        enq       = !known;
                    end
                end
            end
            default: begin
                if (acc) begin
                    split_rsp = 1'b1;
                    enq       = !known && !is_cur;
                end
            end
        endcase
    end

    assign q_push   = enq;
    assign q_front  = s_lock;
    assign q_id     = s_mst;
    assign rel_fire = (state == ST_HELD) || q_pop;
    assign rel_id   = (state == ST_HELD) ? cur_id : q_head;

    // Sequence the access in service through fetch, release and return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_id    <= '0;
            cap_addr  <= '0;
            cap_wr    <= 1'b0;
            cap_wdata <= '0;
            rbuf      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (serve_new) begin
                        state  <= ST_FETCH;
                        cur_id <= s_mst;
                    end else if (q_pop) begin
                        state  <= ST_GRANT;
                        cur_id <= q_head;
                    end
                end
                ST_GRANT:  if (serve_new) state <= ST_FETCH;
                ST_FETCH: begin
                    if (d_done) begin
                        state <= ST_HELD;
                        rbuf  <= d_rdata;
                    end
                end
                ST_HELD:   state <= ST_RETURN;
                ST_RETURN: if (complete) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
            if (serve_new) begin
                cap_addr  <= s_addr;
                cap_wr    <= s_write;
                cap_wdata <= s_wdata;
            end
        end
    end

    // Drive the response phase that follows each accepted address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rph     <= RP_NONE;
            rdata_q <= '0;
        end else begin
            if (rph == RP_SPLIT_WAIT)        rph <= RP_SPLIT_DONE;
            else if (serve_new || split_rsp) rph <= RP_SPLIT_WAIT;
            else if (complete)               rph <= RP_OKAY;
            else                             rph <= RP_NONE;
            rdata_q <= complete ? rbuf : '0;
        end
    end

    assign d_req   = (state == ST_FETCH);
    assign d_write = cap_wr;
    assign d_addr  = cap_addr;
    assign d_wdata = cap_wdata;

endmodule

// File: rtl/split_order_bridge.sv
// Module: top of the split-transaction ordering bridge.
// Connects the controller, the ordered waiting queue and the release
// pulse generator. Assumes the arbiter honours s_split_rel and that the
// downstream side answers each d_req with one d_done pulse.
module split_order_bridge #(
    parameter int NUM_MST = 16,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int MST_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_sel,
    input  logic [MST_W-1:0]   s_mst,
    input  logic               s_write,
    input  logic               s_lock,
    input  logic [ADDR_W-1:0]  s_addr,
    input  logic [DATA_W-1:0]  s_wdata,
    output logic               s_ready,
    output logic [1:0]         s_resp,
    output logic [DATA_W-1:0]  s_rdata,
    output logic [NUM_MST-1:0] s_split_rel,
    output logic               d_req,
    output logic               d_write,
    output logic [ADDR_W-1:0]  d_addr,
    output logic [DATA_W-1:0]  d_wdata,
    input  logic               d_done,
    input  logic [DATA_W-1:0]  d_rdata
);
    logic               q_push, q_front, q_pop, q_empty, q_full;
    logic [MST_W-1:0]   q_id, q_head, rel_id;
    logic [NUM_MST-1:0] q_member;
    logic               rel_fire;

    split_order_ctl #(
        .NUM_MST(NUM_MST), .MST_W(MST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .s_sel(s_sel), .s_mst(s_mst), .s_write(s_write), .s_lock(s_lock),
        .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_resp(s_resp), .s_rdata(s_rdata),
        .d_req(d_req), .d_write(d_write), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_done(d_done), .d_rdata(d_rdata),
        .q_push(q_push), .q_front(q_front), .q_id(q_id), .q_pop(q_pop),
        .q_empty(q_empty), .q_head(q_head), .q_member(q_member),
        .rel_fire(rel_fire), .rel_id(rel_id)
    );

    split_order_fifo #(.NUM_MST(NUM_MST), .MST_W(MST_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_front(q_front), .push_id(q_id), .pop(q_pop),
        .head_id(q_head), .empty(q_empty), .full(q_full), .member(q_member)
    );

    split_release_pulse #(.NUM_MST(NUM_MST), .MST_W(MST_W)) u_rel (
        .clk(clk), .rst_n(rst_n),
        .fire(rel_fire), .id(rel_id), .rel(s_split_rel)
    );

endmodule

// File: rtl/split_order_bridge_chk.sv
// Module: protocol checker for the split ordering bridge, bound to the top.
module split_order_bridge_chk #(
    parameter int NUM_MST = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_ready,
    input logic [1:0]         s_resp,
    input logic [NUM_MST-1:0] s_split_rel,
    input logic               d_req,
    input logic               d_done,
    input logic               q_push,
    input logic               q_pop,
    input logic               q_full
);
    // R3: the waiting queue is never pushed beyond its depth.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && !q_pop) |-> !q_full);

    // R2: a wait state only occurs as the first cycle of a SPLIT, followed by its second.
    assert_split_two_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |-> (s_resp == 2'b11));
    assert_split_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |=> (s_ready && s_resp == 2'b11));

    // R2: forwarding downstream coincides with the SPLIT answer to the master.
    assert_fwd_with_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_req) |-> (!s_ready && s_resp == 2'b11));

    // R4: at most one master released at a time, for a single cycle.
    assert_release_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_split_rel));
    assert_release_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_split_rel != '0) |=> (s_split_rel == '0));

    // R10: the request holds until done and drops right after it.
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && !d_done) |=> d_req);
    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_done) |=> !d_req);

endmodule

bind split_order_bridge split_order_bridge_chk #(.NUM_MST(NUM_MST)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .s_resp(s_resp),
    .s_split_rel(s_split_rel), .d_req(d_req), .d_done(d_done),
    .q_push(q_push), .q_pop(q_pop), .q_full(q_full)
);

// File: tb/split_order_bridge_test.sv
// Directed bench: one task per scenario, each checking its own results.
module split_order_bridge_test;
    localparam int NM = 16;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_sel = 1'b0;
    logic [MW-1:0] s_mst = '0;
    logic          s_write = 1'b0;
    logic          s_lock = 1'b0;
    logic [31:0]   s_addr = '0;
    logic [31:0]   s_wdata = '0;
    logic          s_ready;
    logic [1:0]    s_resp;
    logic [31:0]   s_rdata;
    logic [NM-1:0] s_split_rel;
    logic          d_req, d_write;
    logic [31:0]   d_addr, d_wdata;
    logic          d_done = 1'b0;
    logic [31:0]   d_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    split_order_bridge #(.NUM_MST(NM), .ADDR_W(32), .DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_mst(s_mst),
        .s_write(s_write), .s_lock(s_lock), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_resp(s_resp), .s_rdata(s_rdata),
        .s_split_rel(s_split_rel), .d_req(d_req), .d_write(d_write),
        .d_addr(d_addr), .d_wdata(d_wdata), .d_done(d_done), .d_rdata(d_rdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NM-1:0] bit_of(input int m);
        return NM'(1) << m;
    endfunction

    // Address phase from master m; checks the response phase(s). Called at a negedge.
    task automatic access(input int m, input bit wr, input bit lk, input logic [31:0] a,
                          input logic [31:0] wd, input bit exp_ok,
                          input logic [31:0] exp_rd, input string tag);
        s_sel = 1'b1; s_mst = MW'(m); s_write = wr; s_lock = lk;
        s_addr = a; s_wdata = wd;
        @(negedge clk);
        s_sel = 1'b0; s_lock = 1'b0;
        if (exp_ok) begin
            check(s_ready && s_resp == 2'b00, {tag, " okay"}, {s_ready, s_resp}, 3'b100);
            if (!wr) check(s_rdata == exp_rd, {tag, " rdata"}, s_rdata, exp_rd);
        end else begin
            check(!s_ready && s_resp == 2'b11, {tag, " split1"}, {s_ready, s_resp}, 3'b011);
            @(negedge clk);
            check(s_ready && s_resp == 2'b11, {tag, " split2"}, {s_ready, s_resp}, 3'b111);
        end
    endtask

    // Serve the outstanding downstream access and check the release timing.
    task automatic finish_down(input int m, input logic [31:0] a, input bit wr,
                               input logic [31:0] wd, input logic [31:0] rd,
                               input int dly, input string tag);
        int n = 0;
        while (!d_req && n < 50) begin @(negedge clk); n++; end
        check(d_req == 1'b1, {tag, " R2 d_req"}, d_req, 1);
        check(d_addr == a, {tag, " R2 d_addr"}, d_addr, a);
        check(d_write == wr, {tag, " R2 d_write"}, d_write, wr);
        if (wr) check(d_wdata == wd, {tag, " R2 d_wdata"}, d_wdata, wd);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check(d_req == 1'b1, {tag, " R10 held"}, d_req, 1);
        end
        d_done = 1'b1; d_rdata = rd;
        @(negedge clk);
        d_done = 1'b0;
        check(d_req == 1'b0, {tag, " R10 drop"}, d_req, 0);
        check(s_split_rel == '0, {tag, " R4 early"}, s_split_rel, 0);
        @(negedge clk);
        check(s_split_rel == bit_of(m), {tag, " R4 release"}, s_split_rel, bit_of(m));
        @(negedge clk);
        check(s_split_rel == '0, {tag, " R4 pulse"}, s_split_rel, 0);
    endtask

    // Returning master completes; the next cycle shows the next release (or none).
    task automatic give_back(input int m, input bit wr, input logic [31:0] a,
                             input logic [31:0] rd, input int nxt, input string tag);
        access(m, wr, 1'b0, a, '0, 1'b1, rd, {tag, " R5"});
        @(negedge clk);
        if (nxt < 0)
            check(s_split_rel == '0, {tag, " R6 none"}, s_split_rel, 0);
        else
            check(s_split_rel == bit_of(nxt), {tag, " R6 next"}, s_split_rel, bit_of(nxt));
    endtask

    task automatic quiet(input int cyc, input string tag);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            check(s_split_rel == '0, {tag, " quiet"}, s_split_rel, 0);
        end
    endtask

    task automatic t_reset;
        check(s_ready == 1'b1, "R1 ready", s_ready, 1);
        check(s_resp == 2'b00, "R1 resp", s_resp, 0);
        check(s_split_rel == '0, "R1 release", s_split_rel, 0);
        check(d_req == 1'b0, "R1 d_req", d_req, 0);
    endtask

    // R2 R4 R5: single read and single write through an empty bridge.
    task automatic t_single;
        access(2, 1'b0, 1'b0, 32'h1000_0040, '0, 1'b0, '0, "R2 read");
        finish_down(2, 32'h1000_0040, 1'b0, '0, 32'hCAFE_0002, 2, "single rd");
        give_back(2, 1'b0, 32'h1000_0040, 32'hCAFE_0002, -1, "single rd");
        access(11, 1'b1, 1'b0, 32'h2000_0008, 32'h55AA_0011, 1'b0, '0, "R2 write");
        finish_down(11, 32'h2000_0008, 1'b1, 32'h55AA_0011, '0, 0, "single wr");
        give_back(11, 1'b1, 32'h2000_0008, '0, -1, "single wr");
    endtask

    // R3 R6 R7 R9: masters 0, 3, 5 in arrival order, with an early retry of 3.
    task automatic t_order;
        access(0, 1'b0, 1'b0, 32'hA0, '0, 1'b0, '0, "R2 m0");
        access(3, 1'b0, 1'b0, 32'hA3, '0, 1'b0, '0, "R3 m3");
        access(5, 1'b0, 1'b0, 32'hA5, '0, 1'b0, '0, "R3 m5");
        access(3, 1'b0, 1'b0, 32'hA3, '0, 1'b0, '0, "R9 m3 retry");
        finish_down(0, 32'hA0, 1'b0, '0, 32'hD000, 1, "order m0");
        give_back(0, 1'b0, 32'hA0, 32'hD000, 3, "R6 order m0");
        access(3, 1'b0, 1'b0, 32'hA3, '0, 1'b0, '0, "R7 m3");
        finish_down(3, 32'hA3, 1'b0, '0, 32'hD003, 0, "R7 m3");
        give_back(3, 1'b0, 32'hA3, 32'hD003, 5, "R6 order m3");
        access(5, 1'b0, 1'b0, 32'hA5, '0, 1'b0, '0, "R7 m5");
        finish_down(5, 32'hA5, 1'b0, '0, 32'hD005, 0, "R7 m5");
        give_back(5, 1'b0, 32'hA5, 32'hD005, -1, "R9 no dup");
        quiet(6, "R9");
    endtask

    // R8: locked master 7 jumps ahead of waiting masters 1 and 2.
    task automatic t_lock;
        access(0, 1'b0, 1'b0, 32'hB0, '0, 1'b0, '0, "R2 m0 lk");
        access(1, 1'b0, 1'b0, 32'hB1, '0, 1'b0, '0, "R3 m1");
        access(2, 1'b0, 1'b0, 32'hB2, '0, 1'b0, '0, "R3 m2");
        access(7, 1'b0, 1'b1, 32'hB7, '0, 1'b0, '0, "R8 m7 lock");
        finish_down(0, 32'hB0, 1'b0, '0, 32'hE000, 0, "lock m0");
        give_back(0, 1'b0, 32'hB0, 32'hE000, 7, "R8 first");
        access(7, 1'b0, 1'b0, 32'hB7, '0, 1'b0, '0, "R7 m7");
        finish_down(7, 32'hB7, 1'b0, '0, 32'hE007, 0, "R8 m7");
        give_back(7, 1'b0, 32'hB7, 32'hE007, 1, "R8 then m1");
        access(1, 1'b0, 1'b0, 32'hB1, '0, 1'b0, '0, "R7 m1");
        finish_down(1, 32'hB1, 1'b0, '0, 32'hE001, 0, "R8 m1");
        give_back(1, 1'b0, 32'hB1, 32'hE001, 2, "R8 then m2");
        access(2, 1'b0, 1'b0, 32'hB2, '0, 1'b0, '0, "R7 m2");
        finish_down(2, 32'hB2, 1'b0, '0, 32'hE002, 0, "R8 m2");
        give_back(2, 1'b0, 32'hB2, 32'hE002, -1, "R8 end");
    endtask

    // R11 R10: the master in service retries early; long downstream delay.
    task automatic t_self_retry;
        access(4, 1'b0, 1'b0, 32'hC4, '0, 1'b0, '0, "R2 m4");
        access(4, 1'b0, 1'b0, 32'hC4, '0, 1'b0, '0, "R11 m4 retry");
        finish_down(4, 32'hC4, 1'b0, '0, 32'hF004, 20, "R11 m4");
        give_back(4, 1'b0, 32'hC4, 32'hF004, -1, "R11 not queued");
        quiet(4, "R11");
        access(9, 1'b0, 1'b0, 32'hC9, '0, 1'b0, '0, "R11 m9 direct");
        finish_down(9, 32'hC9, 1'b0, '0, 32'hF009, 0, "R11 m9");
        give_back(9, 1'b0, 32'hC9, 32'hF009, -1, "R11 m9");
    endtask

    // R3 R6: a new split arrives on the same edge as the pop of the queue head.
    task automatic t_collide;
        access(0, 1'b0, 1'b0, 32'hD0, '0, 1'b0, '0, "R2 m0 col");
        access(1, 1'b0, 1'b0, 32'hD1, '0, 1'b0, '0, "R3 m1 col");
        finish_down(0, 32'hD0, 1'b0, '0, 32'h1234, 0, "col m0");
        access(0, 1'b0, 1'b0, 32'hD0, '0, 1'b1, 32'h1234, "R5 col m0");
        s_sel = 1'b1; s_mst = MW'(6); s_write = 1'b0; s_addr = 32'hD6;
        @(negedge clk);
        s_sel = 1'b0;
        check(!s_ready && s_resp == 2'b11, "R3 col m6 split", {s_ready, s_resp}, 3'b011);
        check(s_split_rel == bit_of(1), "R6 col release m1", s_split_rel, bit_of(1));
        @(negedge clk);
        check(s_ready && s_resp == 2'b11, "R3 col m6 split2", {s_ready, s_resp}, 3'b111);
        access(1, 1'b0, 1'b0, 32'hD1, '0, 1'b0, '0, "R7 col m1");
        finish_down(1, 32'hD1, 1'b0, '0, 32'h5678, 0, "col m1");
        give_back(1, 1'b0, 32'hD1, 32'h5678, 6, "R6 col then m6");
        access(6, 1'b0, 1'b0, 32'hD6, '0, 1'b0, '0, "R7 col m6");
        finish_down(6, 32'hD6, 1'b0, '0, 32'h9ABC, 0, "col m6");
        give_back(6, 1'b0, 32'hD6, 32'h9ABC, -1, "col end");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_order();
        t_lock();
        t_self_retry();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule